// File: doc/BRIEF.md
# Asynchronous Static RAM Request Controller

This block sits between an internal single-word request port and an external asynchronous 16-bit static RAM. Each accepted request becomes one complete pin sequence on the memory side. That sequence uses a word address, a pair of chip selects of opposite polarity, an output-enable strobe, a write strobe and one enable per byte lane. Every interval on that sequence is a whole number of clock cycles. The cycle counts are derived at elaboration time from nanosecond parameters and the clock period, always rounding up. For a 10 ns clock this gives a 6-cycle read, a 4-cycle write strobe, a 5-cycle write cycle and a 2-cycle bus turnaround.

Requests use a valid/ready handshake and are served one at a time. A write carries a two-bit lane mask that selects which bytes are stored. A read always fetches the whole word. The result comes back as a registered word together with a one-cycle completion pulse. Writes complete with the same pulse.

The shared data bus is split into an output value, an output-enable and an input value, so that the pad ring can build the tri-state buffer. Every memory-side control pin is driven straight from a flip-flop.

Top module: `asram_ctrl`

## Requirements
- R1: `reqReady` is high exactly when no operation is in flight, including the cycle in which `rspDone` pulses. A request is taken at a rising edge where `reqValid` and `reqReady` are both high. Request fields presented while `reqReady` is low have no effect.
- R2: After reset, and whenever no memory access is running, the memory pins are idle: `memCsN`=1, `memCs`=0, `memOeN`=1, `memWeN`=1, both bits of `memLaneN`=1, and `memDqOe`=0.
- R3: A read accepted at edge A drives the following pins for exactly 6 cycles (edges A+1 to A+7) with `memWeN` held high: `memCsN`=0, `memCs`=1, `memOeN`=0, `memLaneN`=00, and the request address on `memAddr`. The data word is sampled at the edge where these pins return to idle.
- R4: `rspDone` is a single-cycle pulse. For a read it appears 7 cycles after the accepting edge, and `rspData` then equals the word most recently written to that address, or 0 if the address was never written.
- R5: For a write accepted at edge A, `memWeN` is low for exactly 4 cycles starting at edge A+1. During those cycles `memAddr` and `memDqOut` hold the request address and data, so the data is stable for at least 3 cycles before `memWeN` rises.
- R6: The write ends when `memWeN` rises. The chip selects, lane enables, address and driven data stay in place for one more cycle, so the chip selects are active for 5 cycles. `rspDone` pulses 6 cycles after the accepting edge.
- R7: `reqMask` bit 0 = 1 stores bits 7:0 by pulling `memLaneN[0]` low. Bit 1 = 1 stores bits 15:8 through `memLaneN[1]`. An unselected lane keeps its old contents. A mask of 00 pulls no lane enable low, leaves the memory unchanged and still completes with `rspDone`.
- R8: `memDqOe` is high only during a write, from the edge where `memWeN` falls to one cycle after it rises. It is never high while `memOeN` is low.
- R9: After `memOeN` rises at the end of a read, at least 2 cycles pass before `memDqOe` rises, so the controller never drives the bus while the memory may still be driving it.
- R10: `memOeN` and `memWeN` are never low in the same cycle.
- R11: A request presented with `reqValid` held high is accepted in the same cycle as the previous operation's `rspDone`, without disturbing the returned data.
- R12: `rspData` changes only at a read completion and keeps its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte lanes to store (bit 0 = bits 7:0) |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Last word read |
| memAddr | output | 19 | Memory address pins |
| memCsN | output | 1 | Chip select, active low |
| memCs | output | 1 | Chip select, active high |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memLaneN | output | 2 | Byte lane enables, active low (bit 0 = bits 7:0) |
| memDqOut | output | 16 | Value to drive on the data bus |
| memDqOe | output | 1 | Drive enable for the data bus |
| memDqIn | input | 16 | Value seen on the data bus |

## Verification
The completion pulse of one operation and the acceptance of the next share a cycle whenever the request side keeps `reqValid` high. That same cycle also starts the turnaround from a read's output enable to a following write's bus drive. The bench provokes this with back-to-back request streams that mix reads and writes, and it presents junk payloads while the controller is busy. Each cycle it compares the ready and done outputs, the returned word and every memory pin against a behavioural schedule. A behavioural memory on the pins judges bus overlap against a 2-cycle release time of its own, and it also judges the strobe, setup and cycle minima.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RD,
    ST_WR,
    ST_REC
  } ctlState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic load;     // latch request fields
    logic rdBegin;  // raise read pins
    logic wrBegin;  // raise write pins and drive bus
    logic weEnd;    // release write strobe
    logic capture;  // sample memory data into response
    logic finish;   // return pins to idle, pulse done
  } dpStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 6,
  parameter int WEP_CYC = 4,
  parameter int REC_CYC = 1,
  parameter int TA_CYC  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output dpStrobe_t stb
);

  localparam int CNT_MAX = maxOf(maxOf(RD_CYC, WEP_CYC), REC_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int GAP_W   = $clog2(TA_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WEP_LOAD = CNT_W'(WEP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_LIM  = GAP_W'(TA_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(TA_CYC);

  ctlState_t         state, stateNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic [GAP_W-1:0]  gapCnt;
  logic              opWrite;
  logic              lastRead;
  logic              gapOk;

  assign reqReady = (state == ST_IDLE);
  // a write may start only once the read's output enable has been high long enough
  assign gapOk = !lastRead || (gapCnt >= GAP_LIM);

  always_comb begin
    stb       = '0;
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.load  = 1'b1;
          stateNext = ST_START;
        end
      end
      ST_START: begin
        if (!opWrite) begin
          stb.rdBegin = 1'b1;
          stateNext   = ST_RD;
          cntNext     = RD_LOAD;
        end else if (gapOk) begin
          stb.wrBegin = 1'b1;
          stateNext   = ST_WR;
          cntNext     = WEP_LOAD;
        end
      end
      ST_RD: begin
        if (cnt == '0) begin
          stb.capture = 1'b1;
          stb.finish  = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WR: begin
        if (cnt == '0) begin
          stb.weEnd = 1'b1;
          stateNext = ST_REC;
          cntNext   = REC_LOAD;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_REC: begin
        if (cnt == '0) begin
          stb.finish = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opWrite <= 1'b0;
    end else if (stb.load) begin
      opWrite <= reqWrite;
    end
  end

  // turnaround tracking: cycles since a read released the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastRead <= 1'b0;
      gapCnt   <= GAP_SAT;
    end else begin
      if (stb.capture) begin
        lastRead <= 1'b1;
      end else if (stb.wrBegin) begin
        lastRead <= 1'b0;
      end
      if (stb.capture) begin
        gapCnt <= '0;
      end else if (gapCnt != GAP_SAT) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/asram_dp.sv
`timescale 1ns/1ps
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                stb,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W/LANE_W-1:0] reqMask,
  input  logic                     reqWrite,
  input  logic [DATA_W-1:0]        memDqIn,
  output logic                     rspDone,
  output logic [DATA_W-1:0]        rspData,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memCsN,
  output logic                     memCs,
  output logic                     memOeN,
  output logic                     memWeN,
  output logic [DATA_W/LANE_W-1:0] memLaneN,
  output logic [DATA_W-1:0]        memDqOut,
  output logic                     memDqOe
);

  localparam int LANES = DATA_W / LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic              begins;

  assign begins = stb.rdBegin | stb.wrBegin;

  // request holding registers; a read stores no mask so its lanes all open
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (stb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqWrite ? reqMask : '1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
    end else if (begins) begin
      memAddr <= addrQ;
    end
  end

  // chip selects, one flop per polarity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCsN <= 1'b1;
      memCs  <= 1'b0;
    end else if (begins) begin
      memCsN <= 1'b0;
      memCs  <= 1'b1;
    end else if (stb.finish) begin
      memCsN <= 1'b1;
      memCs  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memOeN <= 1'b1;
    end else if (stb.rdBegin) begin
      memOeN <= 1'b0;
    end else if (stb.finish) begin
      memOeN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWeN <= 1'b1;
    end else if (stb.wrBegin) begin
      memWeN <= 1'b0;
    end else if (stb.weEnd | stb.finish) begin
      memWeN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memDqOe <= 1'b0;
    end else if (stb.wrBegin) begin
      memDqOe <= 1'b1;
    end else if (stb.finish) begin
      memDqOe <= 1'b0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          memLaneN[g] <= 1'b1;
        end else if (begins) begin
          memLaneN[g] <= !maskQ[g];
        end else if (stb.finish) begin
          memLaneN[g] <= 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          memDqOut[g*LANE_W +: LANE_W] <= '0;
        end else if (stb.wrBegin) begin
          memDqOut[g*LANE_W +: LANE_W] <= dataQ[g*LANE_W +: LANE_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspDone <= 1'b0;
      rspData <= '0;
    end else begin
      rspDone <= stb.finish;
      if (stb.capture) begin
        rspData <= memDqIn;
      end
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_READ_NS     = 55,
  parameter int T_WEPULSE_NS  = 35,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_WCYCLE_NS   = 45,
  parameter int TURN_CYC      = 2,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W/LANE_W-1:0] reqMask,
  output logic                     rspDone,
  output logic [DATA_W-1:0]        rspData,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memCsN,
  output logic                     memCs,
  output logic                     memOeN,
  output logic                     memWeN,
  output logic [DATA_W/LANE_W-1:0] memLaneN,
  output logic [DATA_W-1:0]        memDqOut,
  output logic                     memDqOe,
  input  logic [DATA_W-1:0]        memDqIn
);

  localparam int RD_CYC  = ceilDiv(T_READ_NS, CLK_PERIOD_NS);
  localparam int WEP_CYC = maxOf(ceilDiv(T_WEPULSE_NS, CLK_PERIOD_NS),
                                 ceilDiv(T_DSETUP_NS, CLK_PERIOD_NS));
  localparam int WC_CYC  = ceilDiv(T_WCYCLE_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = maxOf(1, WC_CYC - WEP_CYC);
  localparam int TA_CYC  = maxOf(1, TURN_CYC);

  dpStrobe_t stb;

  asram_ctl #(
    .RD_CYC (RD_CYC),
    .WEP_CYC(WEP_CYC),
    .REC_CYC(REC_CYC),
    .TA_CYC (TA_CYC)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .reqWrite(reqWrite),
    .memDqIn (memDqIn),
    .rspDone (rspDone),
    .rspData (rspData),
    .memAddr (memAddr),
    .memCsN  (memCsN),
    .memCs   (memCs),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memLaneN(memLaneN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 16,
  parameter int RD_CYC  = 6,
  parameter int WEP_CYC = 4,
  parameter int TA_CYC  = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqReady,
  input logic                rspDone,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                memCsN,
  input logic                memCs,
  input logic                memOeN,
  input logic                memWeN,
  input logic [DATA_W/8-1:0] memLaneN,
  input logic [DATA_W-1:0]   memDqOut,
  input logic                memDqOe
);

  localparam int RUN_W = 8;
  localparam logic [RUN_W-1:0] RUN_SAT = '1;

  logic [RUN_W-1:0] weLowRun, oeLowRun, oeHighRun;

  // run-length counters of the strobes, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun  <= '0;
      oeLowRun  <= '0;
      oeHighRun <= RUN_SAT;
    end else begin
      weLowRun  <= memWeN ? '0 : ((weLowRun == RUN_SAT) ? weLowRun : weLowRun + 1'b1);
      oeLowRun  <= memOeN ? '0 : ((oeLowRun == RUN_SAT) ? oeLowRun : oeLowRun + 1'b1);
      oeHighRun <= !memOeN ? '0 : ((oeHighRun == RUN_SAT) ? oeHighRun : oeHighRun + 1'b1);
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && !memCs && memOeN && memWeN && (&memLaneN) && !memDqOe)); // R2

  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLowRun >= RUN_W'(RD_CYC))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R4

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowRun >= RUN_W'(WEP_CYC))); // R5

  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !$past(memWeN)) |-> ($stable(memDqOut) && $stable(memAddr))); // R5

  AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN); // R8

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (oeHighRun >= RUN_W'(TA_CYC))); // R9

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN)); // R10

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RD_CYC (RD_CYC),
  .WEP_CYC(WEP_CYC),
  .TA_CYC (TA_CYC)
) chk_i (.*);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  localparam int AW       = 19;
  localparam int DW       = 16;
  localparam int RD_MIN   = 6;   // R3
  localparam int WEP_MIN  = 4;   // R5
  localparam int DSU_MIN  = 3;   // R5
  localparam int WC_MIN   = 5;   // R6
  localparam int HOLD_CYC = 2;   // R9: memory may drive this long after OE rises

  typedef struct {
    bit         wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0] mask;
    int         gap;
  } op_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          reqValid, reqReady, reqWrite;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;
  logic [1:0]    reqMask;
  logic          rspDone;
  logic [DW-1:0] rspData;
  logic [AW-1:0] memAddr;
  logic          memCsN, memCs, memOeN, memWeN, memDqOe;
  logic [1:0]    memLaneN;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn;

  asram_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspDone(rspDone), .rspData(rspData),
    .memAddr(memAddr), .memCsN(memCsN), .memCs(memCs), .memOeN(memOeN),
    .memWeN(memWeN), .memLaneN(memLaneN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCmp = 0;
  int nBad = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // reference store (from requests) and device store (from pins)
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] dev    [int];

  function automatic logic [DW-1:0] rdShadow(input int a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction
  function automatic logic [DW-1:0] rdDev(input int a);
    return dev.exists(a) ? dev[a] : '0;
  endfunction

  // behavioural memory state
  bit            prevRd, prevWr, prevCs, csHadWr;
  int            rdAge, holdLeft, weAge, dAge, csAge;
  logic [AW-1:0] prevAddr, wAddr;
  logic [DW-1:0] prevDq, wData;
  logic [1:0]    wLanes;

  task automatic devStep();
    bit rdAct, wrAct, csAct, drv;
    logic [DW-1:0] word;
    csAct = !memCsN && memCs;
    rdAct = csAct && !memOeN && memWeN;
    wrAct = csAct && !memWeN && (memLaneN != 2'b11);
    // read side
    if (rdAct) rdAge = (prevRd && memAddr == prevAddr) ? rdAge + 1 : 1;
    else rdAge = 0;
    if (prevRd && !rdAct) holdLeft = HOLD_CYC;
    else if (!rdAct && holdLeft > 0) holdLeft--;
    drv = rdAct || (holdLeft > 0);
    chk("R9", "bus overlap", {31'b0, drv && memDqOe}, 0);
    word = rdDev(int'(memAddr));
    if (rdAct && rdAge >= RD_MIN) memDqIn = word;
    else memDqIn = ~word;
    // write side
    if (wrAct) begin
      if (prevWr) chk("R5", "address moved during write", {13'b0, memAddr}, {13'b0, prevAddr});
      chk("R8", "bus driven during write", {31'b0, memDqOe}, 1);
      weAge = prevWr ? weAge + 1 : 1;
      dAge  = (prevWr && memDqOut == prevDq) ? dAge + 1 : 1;
      wAddr = memAddr;
      wData = memDqOut;
      wLanes = ~memLaneN;
      csHadWr = 1'b1;
    end else if (prevWr) begin
      chk("R5", "write strobe cycles", weAge >= WEP_MIN, 1);
      chk("R5", "data setup cycles", dAge >= DSU_MIN, 1);
      word = rdDev(int'(wAddr));
      if (wLanes[0]) word[7:0]  = wData[7:0];
      if (wLanes[1]) word[15:8] = wData[15:8];
      dev[int'(wAddr)] = word;
    end
    // chip select length for write cycles
    if (csAct) csAge = prevCs ? csAge + 1 : 1;
    else begin
      if (prevCs && csHadWr) chk("R6", "write cycle length", csAge >= WC_MIN, 1);
      csHadWr = 1'b0;
      csAge = 0;
    end
    prevRd = rdAct; prevWr = wrAct; prevCs = csAct;
    prevAddr = memAddr; prevDq = memDqOut;
  endtask

  // reference schedule
  op_t           opQ[$];
  op_t           cur;
  bit            curBusy = 0;
  int            curA, curD, gapLeft = 0, sameCnt = 0;
  logic [DW-1:0] curExp, lastRd = '0;

  task automatic step();
    bit busyNow, doneExp, actRd, actWr, act, weLow;
    string pinReq;
    logic [1:0] expLanes;
    @(negedge clk);
    devStep();
    busyNow = curBusy && cyc >= curA && cyc < curD;
    doneExp = curBusy && cyc == curD;
    actRd = curBusy && !cur.wr && cyc >= curA + 1 && cyc <= curA + RD_MIN;
    actWr = curBusy && cur.wr && cyc >= curA + 1 && cyc <= curA + WEP_MIN + 1;
    weLow = actWr && cyc <= curA + WEP_MIN;
    act = actRd || actWr;
    pinReq = act ? (actRd ? "R3" : "R6") : "R2";
    chk("R1", "ready", {31'b0, reqReady}, {31'b0, !busyNow});
    chk("R4", "done", {31'b0, rspDone}, {31'b0, doneExp});
    if (doneExp && !cur.wr) lastRd = curExp;
    chk(doneExp ? "R4" : "R12", "read data", {16'b0, rspData}, {16'b0, lastRd});
    chk(pinReq, "csN", {31'b0, memCsN}, {31'b0, !act});
    chk(pinReq, "cs", {31'b0, memCs}, {31'b0, act});
    chk(pinReq, "oeN", {31'b0, memOeN}, {31'b0, !actRd});
    chk(actWr ? "R5" : pinReq, "weN", {31'b0, memWeN}, {31'b0, !weLow});
    chk("R10", "oe and we together", {31'b0, !memOeN && !memWeN}, 0);
    expLanes = actRd ? 2'b00 : (actWr ? ~cur.mask : 2'b11);
    chk(actWr ? "R7" : pinReq, "lanes", {30'b0, memLaneN}, {30'b0, expLanes});
    chk("R8", "drive enable", {31'b0, memDqOe}, {31'b0, actWr});
    if (act) chk(pinReq, "address", {13'b0, memAddr}, {13'b0, cur.addr});
    if (actWr) chk("R5", "write data", {16'b0, memDqOut}, {16'b0, cur.data});
    if (doneExp) curBusy = 0;
    // drive the request side for the next edge
    if (opQ.size() > 0 && gapLeft == 0) begin
      reqValid = 1'b1;
      if (reqReady) begin
        cur = opQ.pop_front();
        reqWrite = cur.wr; reqAddr = cur.addr; reqWdata = cur.data; reqMask = cur.mask;
        curA = cyc + 1;
        curD = curA + (cur.wr ? WEP_MIN + 2 : RD_MIN + 1);
        curBusy = 1;
        if (doneExp) sameCnt++;
        if (cur.wr) begin
          logic [DW-1:0] w;
          w = rdShadow(int'(cur.addr));
          if (cur.mask[0]) w[7:0]  = cur.data[7:0];
          if (cur.mask[1]) w[15:8] = cur.data[15:8];
          shadow[int'(cur.addr)] = w;
        end else begin
          curExp = rdShadow(int'(cur.addr));
        end
        gapLeft = (opQ.size() > 0) ? opQ[0].gap : 0;
      end else begin
        // junk while not ready: must be ignored (R1)
        reqWrite = ~opQ[0].wr; reqAddr = ~opQ[0].addr;
        reqWdata = ~opQ[0].data; reqMask = ~opQ[0].mask;
      end
    end else begin
      reqValid = 1'b0;
      reqWrite = $urandom_range(0, 1);
      reqAddr  = AW'($urandom);
      reqWdata = DW'($urandom);
      reqMask  = 2'($urandom);
      if (gapLeft > 0) gapLeft--;
    end
  endtask

  function automatic op_t mk(input bit wr, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input logic [1:0] m, input int g);
    op_t o;
    o.wr = wr; o.addr = a; o.data = d; o.mask = m; o.gap = g;
    return o;
  endfunction

  bit timedOut = 0;

  initial begin
    logic [AW-1:0] pool [8];
    reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0; reqMask = '0;
    memDqIn = '0;
    pool = '{19'h00000, 19'h7FFFF, 19'h00005, 19'h12345, 19'h40000, 19'h00001, 19'h3FFFF, 19'h2AAAA};
    // directed: extremes, then byte lanes (R7)
    opQ.push_back(mk(1, 19'h00000, 16'hA1B2, 2'b11, 0));
    opQ.push_back(mk(1, 19'h7FFFF, 16'hC3D4, 2'b11, 0));
    opQ.push_back(mk(0, 19'h00000, '0, 2'b00, 0));
    opQ.push_back(mk(0, 19'h7FFFF, '0, 2'b00, 3));
    opQ.push_back(mk(1, 19'h00005, 16'h1234, 2'b11, 0));
    opQ.push_back(mk(1, 19'h00005, 16'hABCD, 2'b01, 0));  // R7 low lane -> 12CD
    opQ.push_back(mk(0, 19'h00005, '0, 2'b00, 0));
    opQ.push_back(mk(1, 19'h00005, 16'hEF99, 2'b10, 0));  // R7 high lane -> EFCD
    opQ.push_back(mk(1, 19'h00005, 16'h0000, 2'b00, 0));  // R7 empty mask
    opQ.push_back(mk(0, 19'h00005, '0, 2'b00, 10));
    opQ.push_back(mk(0, 19'h12345, '0, 2'b00, 0));        // never written -> 0
    for (int i = 0; i < 160; i++) begin
      opQ.push_back(mk($urandom_range(0, 1), pool[$urandom_range(0, 7)],
                       DW'($urandom), 2'($urandom),
                       ($urandom_range(0, 3) == 0) ? $urandom_range(7, 10) : 0));
    end
    repeat (3) @(negedge clk);
    // reset state (R2)
    chk("R2", "reset csN", {31'b0, memCsN}, 1);
    chk("R2", "reset cs", {31'b0, memCs}, 0);
    chk("R2", "reset oeN", {31'b0, memOeN}, 1);
    chk("R2", "reset weN", {31'b0, memWeN}, 1);
    chk("R2", "reset lanes", {30'b0, memLaneN}, 32'h3);
    chk("R2", "reset drive", {31'b0, memDqOe}, 0);
    chk("R4", "reset done", {31'b0, rspDone}, 0);
    rstN = 1'b1;
    while (!(opQ.size() == 0 && !curBusy) && !timedOut) begin
      step();
      if (cyc > 100000) begin
        timedOut = 1;
        nBad++;
        $display("FAIL watchdog at cycle %0d: actual busy expected finished", cyc);
      end
    end
    repeat (3) step();
    chk("R11", "accept in done cycle seen", {31'b0, sameCnt > 0}, 1);
    chk("R7", "device low lane result", {16'b0, rdDev(5)}, {16'b0, rdShadow(5)});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule